// File: doc/BRIEF.md
# Integer Execute Unit

This block is the execute stage of a small fixed-format integer pipeline. Each clock it takes one 32-bit instruction word, a strobe that marks the word as live, and the two source operand values that an external register file has already read. It decodes the word itself and produces a registered writeback triple one clock later: a write strobe, a 5-bit destination index and a 32-bit result.

The decode chooses among several options. The instruction format decides which field names the destination. The opcode decides whether the immediate is sign-extended or zero-extended. The function code decides whether a shift amount comes from the instruction word or from the first source operand.

The input side carries no ready signal and never stalls. A word offered with the strobe high is always taken on the next rising edge. The write strobe on the output acts as the valid of the writeback stream. A downstream register file must accept it in the same cycle it appears, so there is no back-pressure path.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the write strobe, the destination index and the result to zero on the next rising edge.
- R2: Outputs are registered. A word presented before an edge is reflected on the outputs just after that edge and not before.
- R3: Opcode 0 with function code 32 writes `src_rs + src_rt` and function code 34 writes `src_rs - src_rt`. Both wrap modulo 2^32. The destination is bits [15:11].
- R4: Opcode 0 with function codes 36, 37, 38 and 39 writes the bitwise AND, OR, XOR and NOR of the two sources to bits [15:11].
- R5: Opcode 8 adds the sign-extended immediate in bits [15:0] to `src_rs` and writes to the index in bits [20:16].
- R6: Opcodes 12, 13 and 14 AND, OR and XOR `src_rs` with the zero-extended immediate in bits [15:0], writing to bits [20:16].
- R7: Opcode 0 with function codes 0 (left) and 2 (logical right) shifts `src_rt` by the amount in bits [10:6], from 0 to 31, filling with zeros.
- R8: Opcode 0 with function codes 4, 6 and 7 shift `src_rt` left, logically right and arithmetically right by `src_rs[4:0]`. The upper bits of `src_rs` have no effect.
- R9: The arithmetic right shifts (function codes 3 with amount in bits [10:6], and 7) copy bit 31 into every vacated position, so negative values round toward minus infinity.
- R10: A low input strobe, an unlisted opcode, or an unlisted function code under opcode 0 gives a low write strobe on the next cycle.
- R11: A decoded destination index of 0 gives a low write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is live this cycle |
| instr | input | 32 | Instruction word |
| src_rs | input | 32 | Value of the register named by bits [25:21] |
| src_rt | input | 32 | Value of the register named by bits [20:16] |
| wb_en | output | 1 | Writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |

## Verification
Logic operations run on a pair of operands with mixed bit patterns, so that AND, OR, XOR and NOR each give a different word. Add and subtract cross the 2^32 boundary in both directions. Immediates with the top bit set separate sign extension from zero extension. Shifts use amounts of 0, 31 and mid-range values on negative and positive words, which separates arithmetic fill from logical fill. A variable amount with junk in its upper bits shows that only the low five bits are used. Words with illegal codes, destination 0, or a low strobe show that the write strobe is gated.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

  localparam int unsigned WORD_W = 32;

  // primary opcodes
  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDK = 6'd8;
  localparam logic [5:0] OPC_ANDK = 6'd12;
  localparam logic [5:0] OPC_ORK  = 6'd13;
  localparam logic [5:0] OPC_XORK = 6'd14;

  // function codes under OPC_REG
  localparam logic [5:0] FN_SHL_K = 6'd0;
  localparam logic [5:0] FN_SHR_K = 6'd2;
  localparam logic [5:0] FN_SAR_K = 6'd3;
  localparam logic [5:0] FN_SHL_V = 6'd4;
  localparam logic [5:0] FN_SHR_V = 6'd6;
  localparam logic [5:0] FN_SAR_V = 6'd7;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;
  localparam logic [5:0] FN_AND   = 6'd36;
  localparam logic [5:0] FN_OR    = 6'd37;
  localparam logic [5:0] FN_XOR   = 6'd38;
  localparam logic [5:0] FN_NOR   = 6'd39;

  typedef enum logic [3:0] {
    EX_ADD, EX_SUB, EX_AND, EX_OR, EX_XOR, EX_NOR,
    EX_SHL, EX_SHR, EX_SAR
  } ex_op_e;

  typedef struct packed {
    ex_op_e     op;
    logic       use_imm;
    logic       sext_imm;
    logic       var_amt;
    logic [4:0] dst;
    logic       legal;
  } dec_t;

endpackage

// File: rtl/ieu_decode.sv
module ieu_decode
  import ieu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       unused_rs_field;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign unused_rs_field = ^instr[25:21];

  always_comb begin
    dec          = '0;
    dec.op       = EX_ADD;
    dec.dst      = instr[20:16];
    unique case (opc)
      OPC_REG: begin
        dec.dst   = instr[15:11];
        dec.legal = 1'b1;
        case (fn)
          FN_ADD:   dec.op = EX_ADD;
          FN_SUB:   dec.op = EX_SUB;
          FN_AND:   dec.op = EX_AND;
          FN_OR:    dec.op = EX_OR;
          FN_XOR:   dec.op = EX_XOR;
          FN_NOR:   dec.op = EX_NOR;
          FN_SHL_K: dec.op = EX_SHL;
          FN_SHR_K: dec.op = EX_SHR;
          FN_SAR_K: dec.op = EX_SAR;
          FN_SHL_V: begin dec.op = EX_SHL; dec.var_amt = 1'b1; end
          FN_SHR_V: begin dec.op = EX_SHR; dec.var_amt = 1'b1; end
          FN_SAR_V: begin dec.op = EX_SAR; dec.var_amt = 1'b1; end
          default:  dec.legal = 1'b0;
        endcase
      end
      OPC_ADDK: begin
        dec.op = EX_ADD; dec.use_imm = 1'b1; dec.sext_imm = 1'b1; dec.legal = 1'b1;
      end
      OPC_ANDK: begin dec.op = EX_AND; dec.use_imm = 1'b1; dec.legal = 1'b1; end
      OPC_ORK:  begin dec.op = EX_OR;  dec.use_imm = 1'b1; dec.legal = 1'b1; end
      OPC_XORK: begin dec.op = EX_XOR; dec.use_imm = 1'b1; dec.legal = 1'b1; end
      default:  dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ieu_arith_logic.sv
module ieu_arith_logic
  import ieu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  ex_op_e       op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      EX_SUB:  res = opa - opb;
      EX_AND:  res = opa & opb;
      EX_OR:   res = opa | opb;
      EX_XOR:  res = opa ^ opb;
      EX_NOR:  res = ~(opa | opb);
      default: res = opa + opb;
    endcase
  end
endmodule

// File: rtl/ieu_shifter.sv
module ieu_shifter #(
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  res
);
  // Left shifts are done as right shifts of the bit-reversed word.
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic         fill;
  logic [W-1:0] stage [AW+1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = val[W-1-i];
    assign rev_out[i] = stage[AW][W-1-i];
  end

  assign fill     = arith & ~left & val[W-1];
  assign stage[0] = left ? rev_in : val;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    assign stage[k+1] = amt[k] ? {{S{fill}}, stage[k][W-1:S]} : stage[k];
  end

  assign res = left ? rev_out : stage[AW];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned IMM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_rs,
  input  logic [DATA_W-1:0] src_rt,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  dec_t              dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] al_res;
  logic [DATA_W-1:0] sh_res;
  logic [AMT_W-1:0]  sh_amt;
  logic              is_shift;
  logic [DATA_W-1:0] result;

  ieu_decode u_dec (.instr(instr), .dec(dec));

  assign imm_ext = {{(DATA_W-IMM_W){dec.sext_imm & instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign opb     = dec.use_imm ? imm_ext : src_rt;

  ieu_arith_logic #(.W(DATA_W)) u_al (
    .op(dec.op), .opa(src_rs), .opb(opb), .res(al_res)
  );

  assign sh_amt   = dec.var_amt ? src_rs[AMT_W-1:0] : instr[6 +: AMT_W];
  assign is_shift = (dec.op == EX_SHL) || (dec.op == EX_SHR) || (dec.op == EX_SAR);

  ieu_shifter #(.W(DATA_W)) u_sh (
    .val(src_rt), .amt(sh_amt),
    .left(dec.op == EX_SHL), .arith(dec.op == EX_SAR),
    .res(sh_res)
  );

  assign result = is_shift ? sh_res : al_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= in_valid & dec.legal & (dec.dst != 5'd0);
      wb_idx  <= dec.dst;
      wb_data <= result;
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] src_rs,
  input logic [DATA_W-1:0] src_rt,
  input logic              wb_en,
  input logic [4:0]        wb_idx,
  input logic [DATA_W-1:0] wb_data
);
  logic is_reg, is_add_r, is_shl_v, is_addk, is_andk;
  assign is_reg   = in_valid && instr[31:26] == 6'd0;
  assign is_add_r = is_reg && instr[5:0] == 6'd32 && instr[15:11] != 5'd0;
  assign is_shl_v = is_reg && instr[5:0] == 6'd4 && instr[15:11] != 5'd0;
  assign is_addk  = in_valid && instr[31:26] == 6'd8 && instr[20:16] != 5'd0;
  assign is_andk  = in_valid && instr[31:26] == 6'd12;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!wb_en && wb_idx == 5'd0 && wb_data == '0));

  a_r3_add_wraps: assert property (@(posedge clk) disable iff (rst)
    is_add_r |=> (wb_en && wb_idx == $past(instr[15:11]) &&
                  wb_data == $past(src_rs + src_rt)));

  a_r5_addk_to_rt: assert property (@(posedge clk) disable iff (rst)
    is_addk |=> (wb_en && wb_idx == $past(instr[20:16]) &&
                 wb_data == $past(src_rs + {{16{instr[15]}}, instr[15:0]})));

  a_r6_andk_upper_zero: assert property (@(posedge clk) disable iff (rst)
    is_andk |=> (wb_data[31:16] == 16'h0));

  a_r8_var_shift_low_bits: assert property (@(posedge clk) disable iff (rst)
    is_shl_v |=> (wb_en && wb_data == $past(src_rt << src_rs[4:0])));

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wb_en);

  a_r11_no_zero_dst: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_idx != 5'd0);
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic        en;
    logic [4:0]  idx;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [31:0] rw(input int rs, input int rt, input int rd,
                                     input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] iw(input int op, input int rs, input int rt,
                                     input logic [15:0] k);
    return {op[5:0], rs[4:0], rt[4:0], k};
  endfunction

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h02324020, 32'd5, 32'd7, 1'b1, 5'd8, 32'd12, 8'd3},                  // R3
    '{rw(1,2,3,0,32), 32'hFFFFFFFF, 32'd2, 1'b1, 5'd3, 32'd1, 8'd3},          // R3 wrap
    '{rw(19,20,10,0,34), 32'd3, 32'd5, 1'b1, 5'd10, 32'hFFFFFFFE, 8'd3},      // R3 sub
    '{rw(1,2,4,0,36), 32'hFFFF0000, 32'h46A1F0B7, 1'b1, 5'd4, 32'h46A10000, 8'd4}, // R4
    '{rw(1,2,5,0,37), 32'hFFFF0000, 32'h46A1F0B7, 1'b1, 5'd5, 32'hFFFFF0B7, 8'd4},
    '{rw(1,2,6,0,38), 32'hFFFF0000, 32'h46A1F0B7, 1'b1, 5'd6, 32'hB95EF0B7, 8'd4},
    '{rw(1,2,7,0,39), 32'hFFFF0000, 32'h46A1F0B7, 1'b1, 5'd7, 32'h00000F48, 8'd4},
    '{32'h2268FFF4, 32'd100, 32'hDEADBEEF, 1'b1, 5'd8, 32'd88, 8'd5},          // R5
    '{32'h3528FF00, 32'h12340012, 32'h0, 1'b1, 5'd8, 32'h1234FF12, 8'd6},      // R6
    '{iw(12,1,9,16'hFF00), 32'hFFFFFFFF, 32'h0, 1'b1, 5'd9, 32'h0000FF00, 8'd6},
    '{iw(14,1,10,16'h8001), 32'hF0F0F0F0, 32'h0, 1'b1, 5'd10, 32'hF0F070F1, 8'd6},
    '{rw(0,17,8,4,0), 32'h0, 32'h80000001, 1'b1, 5'd8, 32'h00000010, 8'd7},    // R7
    '{rw(0,16,10,8,2), 32'h0, 32'h80000000, 1'b1, 5'd10, 32'h00800000, 8'd7},
    '{rw(0,16,11,0,0), 32'h0, 32'hA5A5A5A5, 1'b1, 5'd11, 32'hA5A5A5A5, 8'd7},
    '{rw(0,17,19,4,3), 32'h0, 32'h80000010, 1'b1, 5'd19, 32'hF8000001, 8'd9},  // R9
    '{rw(0,17,19,31,3), 32'h0, 32'h80000000, 1'b1, 5'd19, 32'hFFFFFFFF, 8'd9},
    '{rw(18,17,19,0,4), 32'hFFFFFFE3, 32'd1, 1'b1, 5'd19, 32'd8, 8'd8},        // R8
    '{rw(18,17,20,0,6), 32'h00000024, 32'hF0000000, 1'b1, 5'd20, 32'h0F000000, 8'd8},
    '{rw(18,17,21,0,7), 32'h00000020, 32'h80000000, 1'b1, 5'd21, 32'h80000000, 8'd8},
    '{rw(18,17,21,0,7), 32'd1, 32'hFFFFFFF9, 1'b1, 5'd21, 32'hFFFFFFFC, 8'd9},
    '{rw(1,2,3,0,33), 32'd1, 32'd1, 1'b0, 5'd0, 32'd0, 8'd10},                 // R10
    '{iw(9,1,2,16'h0001), 32'd1, 32'd1, 1'b0, 5'd0, 32'd0, 8'd10},
    '{rw(1,2,0,0,32), 32'd1, 32'd1, 1'b0, 5'd0, 32'd0, 8'd11},                 // R11
    '{iw(8,1,0,16'h0001), 32'd1, 32'd1, 1'b0, 5'd0, 32'd0, 8'd11}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_rs = '0;
  logic [31:0] src_rt = '0;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_rs(src_rs), .src_rt(src_rt),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = v; instr = w; src_rs = a; src_rt = b;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared while reset is held
    check("R1 en", {31'd0, wb_en}, 32'd0);
    check("R1 idx", {27'd0, wb_idx}, 32'd0);
    check("R1 data", wb_data, 32'd0);
    @(negedge clk) rst = 1'b0;

    foreach (VECS[i]) begin
      drive(1'b1, VECS[i].ins, VECS[i].a, VECS[i].b);
      @(posedge clk); #1;
      check($sformatf("R%0d en #%0d", VECS[i].req, i), {31'd0, wb_en}, {31'd0, VECS[i].en});
      if (VECS[i].en) begin
        check($sformatf("R%0d idx #%0d", VECS[i].req, i), {27'd0, wb_idx}, {27'd0, VECS[i].idx});
        check($sformatf("R%0d data #%0d", VECS[i].req, i), wb_data, VECS[i].d);
      end
    end

    // R10: a legal add with the strobe low does not write
    drive(1'b0, 32'h02324020, 32'd1, 32'd1);
    @(posedge clk); #1;
    check("R10 strobe low", {31'd0, wb_en}, 32'd0);

    // R2: outputs hold until the edge that captures the word
    drive(1'b1, rw(1,2,12,0,32), 32'd40, 32'd2);
    #2;
    check("R2 before edge", {31'd0, wb_en}, 32'd0);
    @(posedge clk); #1;
    check("R2 after edge en", {31'd0, wb_en}, 32'd1);
    check("R2 after edge data", wb_data, 32'd42);

    // R1: reset mid-stream clears a pending write
    drive(1'b1, rw(1,2,13,0,32), 32'd1, 32'd1);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid en", {31'd0, wb_en}, 32'd0);
    check("R1 mid data", wb_data, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule